// File: doc/BRIEF.md
# Four-Switch Buck-Boost Gate Steering

This block sits between the pulse-width modulator and the dead-time stage of a four-switch cascaded buck-boost bridge. It takes two modulated streams, one tuned for step-down cycles and one for step-up cycles. It routes the proper stream, and its complement, onto whichever half-bridge must switch. At the same time it pins the other half-bridge in a fixed state. Which half-bridge switches depends on the power-flow direction and on whether the present switching period is a step-down or a step-up cycle. In reverse flow the two roles change places.

The controller requests a conversion mode: step-down, step-up, or alternating. Alternating mode is used when the voltage gain sits close to unity and neither pure mode can regulate. The controller chooses it when the step-down duty would rise above 0.85 or the step-up duty would drop below 0.15. In this mode the block issues a step-down period and then a step-up period, in turn, so that the gain over two periods becomes (1 + Dbuck) / (2 − Dboost). Mode and direction requests are captured only on the counter's period-start pulse, so a period is never reshaped partway through. A run flag forces every gate low while it is deasserted. The four gate enables come out registered, along with a flag that gives the type of the period now in progress.

Top module: `fsbb_gate_steer`

## Requirements
- R1: After reset all four gate outputs are 0, `boost_cycle` is 0, and the latched state is step-down mode with forward flow.
- R2: When `run_en` is 0 in a cycle, all four bits of `gate_sw` are 0 one clock later, whatever the other inputs are.
- R3: In a step-up period with forward flow (`dir_fwd`=1), gate_sw[0] (switch 1) is 1 and gate_sw[1] (switch 2) is 0. gate_sw[3] (switch 4) follows `pwm_boost` and gate_sw[2] (switch 3) follows its complement.
- R4: In a step-down period with forward flow, gate_sw[2] is 1 and gate_sw[3] is 0. gate_sw[0] follows `pwm_buck` and gate_sw[1] follows its complement.
- R5: With reverse flow (`dir_fwd`=0), a step-up period uses the R4 switch pattern driven by `pwm_boost`, and a step-down period uses the R3 switch pattern driven by `pwm_buck`.
- R6: `mode_sel` encodes 00 as step-down, 01 as step-up and 10 as alternating. When alternating mode is entered from another mode, the first period is step-down. After that, each further period-start pulse flips the period type, and each period uses the stream that matches its type.
- R7: `mode_sel` and `dir_fwd` are sampled only in a cycle where `period_start` is 1. Changes in any other cycle leave `boost_cycle` and the switch pattern unchanged.
- R8: The reserved code `mode_sel`=11, sampled on a period-start pulse, leaves the latched mode unchanged. The direction is still taken.
- R9: The two switches of a half-bridge (gate_sw[0]/gate_sw[1], or gate_sw[2]/gate_sw[3]) are never both 1.
- R10: `gate_sw` and `boost_cycle` are registered. They reflect the inputs sampled at the previous rising clock edge, with any mode change from that same edge already applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| run_en | input | 1 | Conversion enable; 0 forces all gates low |
| dir_fwd | input | 1 | Power-flow direction: 1 forward, 0 reverse |
| mode_sel | input | 2 | Requested mode: 00 step-down, 01 step-up, 10 alternating, 11 reserved |
| period_start | input | 1 | One-cycle pulse from the period counter marking a new switching period |
| pwm_buck | input | 1 | Modulated stream for step-down periods |
| pwm_boost | input | 1 | Modulated stream for step-up periods |
| gate_sw | output | 4 | Gate enables for switches 1..4 (bit 0 = switch 1) before dead time |
| boost_cycle | output | 1 | 1 while the current period is a step-up period |

## Verification
A wrong latched mode, direction or alternation phase appears on `boost_cycle` and on which half-bridge sits static. This shows one clock after the period-start pulse that loaded the bad state, and it persists until the next pulse. A corrupted phase appears as two consecutive periods of the same type in alternating mode. A mapping fault shows at once as a wrong stream or an inverted complement on the switching leg. Random traffic mixes pulses, reserved codes and direction flips with constant-run stretches, and every cycle is compared against an independent pattern model.

// File: rtl/fsbb_pkg.sv
package fsbb_pkg;

  typedef enum logic [1:0] {
    MODE_BUCK  = 2'b00,
    MODE_BOOST = 2'b01,
    MODE_ALT   = 2'b10,
    MODE_RSVD  = 2'b11
  } conv_mode_e;

  localparam int unsigned GATE_N    = 4;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned LEG_N     = GATE_N / 2;

endpackage

// File: rtl/fsbb_rst_sync.sv
module fsbb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/fsbb_period_latch.sv
module fsbb_period_latch
  import fsbb_pkg::*;
#(
  parameter bit ALT_START_BOOST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       period_start,
  input  conv_mode_e mode_req,
  input  logic       dir_req,
  output conv_mode_e mode_q,
  output logic       dir_q,
  output logic       phase_q,
  output conv_mode_e mode_nx,
  output logic       dir_nx,
  output logic       phase_nx
);

  localparam logic START_PHASE = ALT_START_BOOST;

  logic ld_en;

  assign ld_en = period_start;

  // next-state: mode and direction are sampled only at a period boundary
  always_comb begin
    mode_nx  = mode_q;
    dir_nx   = dir_q;
    phase_nx = phase_q;
    if (ld_en) begin
      dir_nx = dir_req;
      if (mode_req != MODE_RSVD) begin
        mode_nx = mode_req;
      end
      if (mode_nx == MODE_ALT) begin
        phase_nx = (mode_q == MODE_ALT) ? ~phase_q : START_PHASE;
      end else begin
        phase_nx = START_PHASE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_BUCK;
      dir_q   <= 1'b1;
      phase_q <= START_PHASE;
    end else if (ld_en) begin
      mode_q  <= mode_nx;
      dir_q   <= dir_nx;
      phase_q <= phase_nx;
    end
  end

endmodule

// File: rtl/fsbb_leg_map.sv
module fsbb_leg_map
  import fsbb_pkg::*;
(
  input  conv_mode_e        mode,
  input  logic              dir_fwd,
  input  logic              phase,
  input  logic              pwm_buck,
  input  logic              pwm_boost,
  output logic [GATE_N-1:0] gates,
  output logic              boost_cyc
);

  logic left_static;
  logic mod_src;
  logic [LEG_N-1:0] leg_static;
  logic [1:0] leg_pair [LEG_N];

  always_comb begin
    boost_cyc   = (mode == MODE_BOOST) || ((mode == MODE_ALT) && phase);
    // forward step-up and reverse step-down keep the switch-1 leg static
    left_static = (boost_cyc == dir_fwd);
    mod_src     = boost_cyc ? pwm_boost : pwm_buck;
    leg_static  = {~left_static, left_static};
  end

  // each leg: static leg drives upper on / lower off, switching leg carries
  // the stream on one device and its complement on the other
  for (genvar g = 0; g < LEG_N; g++) begin : g_leg
    always_comb begin
      if (leg_static[g]) begin
        leg_pair[g] = (g == 0) ? 2'b01 : 2'b01;
      end else if (g == 0) begin
        leg_pair[g] = {~mod_src, mod_src};
      end else begin
        leg_pair[g] = {mod_src, ~mod_src};
      end
    end
    assign gates[2*g +: 2] = leg_pair[g];
  end

endmodule

// File: rtl/fsbb_gate_reg.sv
module fsbb_gate_reg
  import fsbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [GATE_N-1:0] gates_in,
  input  logic              boost_in,
  output logic [GATE_N-1:0] gates_q,
  output logic              boost_q
);

  logic [GATE_N-1:0] gates_nx;

  always_comb begin
    gates_nx = run ? gates_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q <= '0;
      boost_q <= 1'b0;
    end else begin
      gates_q <= gates_nx;
      boost_q <= boost_in;
    end
  end

endmodule

// File: rtl/fsbb_gate_steer.sv
module fsbb_gate_steer
  import fsbb_pkg::*;
#(
  parameter int unsigned RST_STAGES      = 2,
  parameter bit          ALT_START_BOOST = 1'b0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              run_en,
  input  logic              dir_fwd,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              period_start,
  input  logic              pwm_buck,
  input  logic              pwm_boost,
  output logic [GATE_N-1:0] gate_sw,
  output logic              boost_cycle
);

  logic              rst_sync_n;
  conv_mode_e        mode_q;
  conv_mode_e        mode_nx;
  logic              dir_q;
  logic              dir_nx;
  logic              phase_q;
  logic              phase_nx;
  logic [GATE_N-1:0] gates_raw;
  logic              boost_raw;

  fsbb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_sync_n)
  );

  fsbb_period_latch #(.ALT_START_BOOST(ALT_START_BOOST)) u_latch (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .period_start (period_start),
    .mode_req     (conv_mode_e'(mode_sel)),
    .dir_req      (dir_fwd),
    .mode_q       (mode_q),
    .dir_q        (dir_q),
    .phase_q      (phase_q),
    .mode_nx      (mode_nx),
    .dir_nx       (dir_nx),
    .phase_nx     (phase_nx)
  );

  // map with next-state so the new period starts on the pulse edge
  fsbb_leg_map u_map (
    .mode      (mode_nx),
    .dir_fwd   (dir_nx),
    .phase     (phase_nx),
    .pwm_buck  (pwm_buck),
    .pwm_boost (pwm_boost),
    .gates     (gates_raw),
    .boost_cyc (boost_raw)
  );

  fsbb_gate_reg u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_en),
    .gates_in (gates_raw),
    .boost_in (boost_raw),
    .gates_q  (gate_sw),
    .boost_q  (boost_cycle)
  );

endmodule

// File: rtl/fsbb_gate_steer_chk.sv
module fsbb_gate_steer_chk
  import fsbb_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic              run_en,
  input logic              period_start,
  input logic [MODE_W-1:0] mode_sel,
  input logic [GATE_N-1:0] gate_sw,
  input logic              boost_cycle,
  input conv_mode_e        mode_q
);

  // R2
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(run_en) |-> (gate_sw == '0));

  // R9
  p_no_shoot_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(gate_sw[0] && gate_sw[1]) && !(gate_sw[2] && gate_sw[3]));

  // R3 R4 R5: exactly the static leg shows upper on, lower off
  p_static_leg_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $past(run_en) |-> ((gate_sw[1:0] == 2'b01) || (gate_sw[3:2] == 2'b01)));

  // R7
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(period_start) |-> ($stable(boost_cycle) && $stable(mode_q)));

  // R6
  p_alt_toggle_r6: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(period_start) && ($past(mode_q) == MODE_ALT) && (mode_q == MODE_ALT))
      |-> (boost_cycle != $past(boost_cycle)));

  // R8
  p_rsvd_keep_r8: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(period_start) && ($past(mode_sel) == 2'b11))
      |-> (mode_q == $past(mode_q)));

endmodule

bind fsbb_gate_steer fsbb_gate_steer_chk u_chk (
  .clk          (clk),
  .srst_n       (rst_sync_n),
  .run_en       (run_en),
  .period_start (period_start),
  .mode_sel     (mode_sel),
  .gate_sw      (gate_sw),
  .boost_cycle  (boost_cycle),
  .mode_q       (mode_q)
);

// File: tb/fsbb_gate_steer_bench.sv
module fsbb_gate_steer_bench;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       run_en;
  logic       dir_fwd;
  logic [1:0] mode_sel;
  logic       period_start;
  logic       pwm_buck;
  logic       pwm_boost;
  logic [3:0] gate_sw;
  logic       boost_cycle;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model state
  logic [1:0] m_mode;
  logic       m_dir;
  logic       m_ph;
  logic [3:0] e_gate;
  logic       e_boost;

  always #10 clk = ~clk;

  fsbb_gate_steer u_fsbb_gate_steer (
    .clk          (clk),
    .arst_n       (arst_n),
    .run_en       (run_en),
    .dir_fwd      (dir_fwd),
    .mode_sel     (mode_sel),
    .period_start (period_start),
    .pwm_buck     (pwm_buck),
    .pwm_boost    (pwm_boost),
    .gate_sw      (gate_sw),
    .boost_cycle  (boost_cycle)
  );

  // switch pattern from the requirement tables (bit0 = switch 1)
  function automatic logic [3:0] pattern(logic step_up, logic fwd,
                                         logic s_dn, logic s_up, logic run);
    logic [3:0] g;
    logic       p;
    p = step_up ? s_up : s_dn;
    if (step_up == fwd) g = {p, ~p, 1'b0, 1'b1};   // switch1 on, switch2 off
    else                g = {1'b0, 1'b1, ~p, p};   // switch3 on, switch4 off
    return run ? g : 4'b0000;
  endfunction

  task automatic model_step();
    logic [1:0] nm;
    if (period_start) begin
      nm = (mode_sel == 2'b11) ? m_mode : mode_sel;
      if (nm == 2'b10) m_ph = (m_mode == 2'b10) ? ~m_ph : 1'b0;
      else             m_ph = 1'b0;
      m_mode = nm;
      m_dir  = dir_fwd;
    end
    e_boost = (m_mode == 2'b01) || (m_mode == 2'b10 && m_ph);
    e_gate  = pattern(e_boost, m_dir, pwm_buck, pwm_boost, run_en);
  endtask

  task automatic check(string tag);
    n_vec++;
    if (gate_sw !== e_gate || boost_cycle !== e_boost) begin
      n_bad++;
      $display("FAIL %s gate_sw=%b boost_cycle=%b expected gate_sw=%b boost_cycle=%b",
               tag, gate_sw, boost_cycle, e_gate, e_boost);
    end
    n_vec++;
    if ((gate_sw[0] && gate_sw[1]) || (gate_sw[2] && gate_sw[3])) begin
      n_bad++;
      $display("FAIL R9 gate_sw=%b expected no leg with both devices on", gate_sw);
    end
  endtask

  function automatic string auto_tag();
    if (!run_en)             return "R2";
    if (m_mode == 2'b10)     return "R6";
    if (!m_dir)              return "R5";
    return e_boost ? "R3" : "R4";
  endfunction

  // drive at a negedge, model the coming edge, check at the next negedge (R10)
  task automatic apply(logic r, logic d, logic [1:0] m, logic ps,
                       logic pdn, logic pup, string tag);
    string t;
    run_en = r; dir_fwd = d; mode_sel = m; period_start = ps;
    pwm_buck = pdn; pwm_boost = pup;
    model_step();
    t = (tag == "") ? auto_tag() : tag;
    @(negedge clk);
    check(t);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    arst_n = 1'b0; run_en = 1'b0; dir_fwd = 1'b1; mode_sel = 2'b00;
    period_start = 1'b0; pwm_buck = 1'b0; pwm_boost = 1'b0;
    m_mode = 2'b00; m_dir = 1'b1; m_ph = 1'b0; e_gate = '0; e_boost = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // R3: forward step-up, stream toggles each cycle (R10 latency)
    apply(1, 1, 2'b01, 1, 0, 1, "R3");
    apply(1, 1, 2'b01, 0, 1, 0, "R10");
    apply(1, 1, 2'b01, 0, 0, 1, "R10");
    // R7: mode and direction change without pulse are ignored
    apply(1, 0, 2'b00, 0, 1, 1, "R7");
    apply(1, 0, 2'b10, 0, 0, 0, "R7");
    // R4: forward step-down
    apply(1, 1, 2'b00, 1, 1, 0, "R4");
    apply(1, 1, 2'b00, 0, 0, 1, "R4");
    // R5: reverse both types
    apply(1, 0, 2'b01, 1, 0, 1, "R5");
    apply(1, 0, 2'b01, 0, 1, 0, "R5");
    apply(1, 0, 2'b00, 1, 1, 0, "R5");
    apply(1, 0, 2'b00, 0, 0, 1, "R5");
    // R8: reserved code keeps step-down, direction still taken
    apply(1, 1, 2'b11, 1, 1, 0, "R8");
    apply(1, 1, 2'b11, 0, 0, 1, "R8");
    // R6: alternating entry starts step-down, then flips per pulse
    apply(1, 1, 2'b10, 1, 1, 0, "R6");
    apply(1, 1, 2'b10, 0, 0, 1, "R6");
    apply(1, 1, 2'b10, 1, 0, 1, "R6");
    apply(1, 1, 2'b11, 1, 1, 1, "R6");
    apply(1, 1, 2'b10, 1, 1, 0, "R6");
    // R2: run low forces gates low
    apply(0, 1, 2'b10, 0, 1, 1, "R2");
    apply(0, 0, 2'b01, 1, 0, 1, "R2");

    for (int i = 0; i < 4000; i++) begin
      logic r, d, ps;
      logic [1:0] m;
      r  = ($urandom % 8) != 0;
      d  = $urandom % 2;
      m  = $urandom % 4;
      ps = ($urandom % 6) == 0;
      apply(r, d, m, ps, 1'($urandom % 2), 1'($urandom % 2), "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule